// File: doc/BRIEF.md
# Configuration Image Header Size Extractor

This block reads the header of a configuration image and returns two numbers: the byte offset where the bitstream payload begins, and the payload length in bytes. Image bytes arrive one at a time with an explicit byte index and are kept in an internal buffer of `BUF_BYTES` entries. A single-cycle `start` then launches a parse over the buffered bytes.

The parse first reads the header length and the number of lookup-table records. It then walks the table, one record at a time, until it has found both the payload record and the component-size record. Next it reads the component count. Last, it unpacks a list of 22-bit component sizes that are packed back to back across byte boundaries and adds them up. The payload length is sixteen times that sum.

The result is reported on a valid flag, or an error flag when the header is malformed. Either flag is held until the next parse is launched. A system controller would load the image head, pulse `start`, wait for `busy` to drop, and use the offset and length to drive the later payload transfer.

Top module: `hdr_size_extract`

## Requirements
- R1: The header length is the byte at image index 24. A value of zero, or a value larger than `BUF_BYTES`, ends the parse with the error flag.
- R2: The lookup-table record count is the byte at index (header length − 1). The table occupies the bytes from the header length up to header length + 9 × count. If the table end exceeds `BUF_BYTES`, the parse ends with an error.
- R3: Each table record is 9 bytes long. Byte 0 of the record holds an ID. Bytes 1..4 hold a 32-bit little-endian offset. ID 8 gives the payload offset and ID 5 gives the start of the size list. Any other ID is skipped. A later ID 8 record seen before both records are found replaces an earlier one.
- R4: The table walk stops at the first record where both IDs have been seen. Records after that point have no effect on the result.
- R5: If the last record is passed without both IDs seen, or the record count is zero, the error flag is raised.
- R6: The component count is a 16-bit little-endian value at indices 55 (low byte) and 56 (high byte). A count of zero gives a valid result with a length of 0.
- R7: Component i is the 22-bit field that starts at bit 22·i of the size list. Bits are numbered LSB-first within each byte, and bytes in ascending order. The reported length is 16 × the sum of all fields, so its low 4 bits are always zero.
- R8: If 16 × the sum does not fit in 32 bits, the parse ends with an error. A sum of exactly 2^28 − 1 gives a valid length of 0xFFFFFFF0.
- R9: A size-list byte needed at an index of `BUF_BYTES` or above ends the parse with an error.
- R10: The valid flag and the error flag are never both high. Both flags, the offset and the length hold steady until the next accepted `start`. An error leaves the offset and the length at zero.
- R11: After the `start` edge, a valid result appears exactly 4 + 5·j + S clock edges later. Here j is the 1-based index of the record that completes the table walk. S is 0 for a zero count; otherwise S = n + ceil(22·n/8). `busy` stays high from the edge after `start` until a flag is raised.
- R12: A byte write while `busy` is high has no effect. A byte write with an index of `BUF_BYTES` or above has no effect.
- R13: After reset, `busy`, `res_valid`, `res_error`, `bs_offset` and `data_bytes` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Image byte write strobe |
| in_index | input | IDX_W | Image byte index of the write |
| in_byte | input | 8 | Image byte value |
| start | input | 1 | Launch a parse (accepted when not busy) |
| busy | output | 1 | Parse in progress |
| res_valid | output | 1 | Result fields are valid |
| res_error | output | 1 | Header was malformed or a limit was hit |
| bs_offset | output | 32 | Payload start offset from the table |
| data_bytes | output | 32 | Payload length in bytes |

## Verification
Every valid result has a fixed due cycle. It is the `start` edge plus 4, plus 5 per record walked, plus one cycle per size-list byte fetched, plus one cycle per component added. The bench computes that count from the image it built and counts rising edges until a flag appears. It compares the count, then samples the result fields at the following falling edge, away from the clock edge. Error results are awaited with a bound. The bench then checks that the flags and fields hold over idle cycles and through writes that must be ignored.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    localparam int WORD_W     = 32;
    localparam int HLEN_POS   = 24;
    localparam int NCOMP_POS  = 55;
    localparam int REC_LEN    = 9;
    localparam int REC_LAST   = 4;
    localparam int FLD_W      = 22;
    localparam int FRAME_LOG2 = 4;
    localparam int TBL_W      = 12;

    localparam logic [7:0] ID_STREAM = 8'd8;
    localparam logic [7:0] ID_SIZES  = 8'd5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HLEN,
        PH_NREC,
        PH_REC,
        PH_CNT_LO,
        PH_CNT_HI,
        PH_SIZES
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] stream_off;
        logic [WORD_W-1:0] sizes_off;
        logic              got_stream;
        logic              got_sizes;
    } scan_t;

    // Fold one completed table record into the scan state.
    function automatic scan_t merge_rec(scan_t cur, logic [7:0] id, logic [WORD_W-1:0] off);
        scan_t nx;
        nx = cur;
        if (id == ID_STREAM) begin
            nx.stream_off = off;
            nx.got_stream = 1'b1;
        end else if (id == ID_SIZES) begin
            nx.sizes_off = off;
            nx.got_sizes = 1'b1;
        end
        return nx;
    endfunction

    // First byte index past the lookup table.
    function automatic logic [TBL_W-1:0] table_end(logic [7:0] hlen, logic [7:0] nrec);
        return TBL_W'(hlen) + TBL_W'(nrec) * TBL_W'(REC_LEN);
    endfunction

endpackage

// File: rtl/hdr_buf.sv
module hdr_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hdr_unpack.sv
module hdr_unpack #(
    parameter int FW = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic          ready,
    output logic [FW-1:0] field
);
    localparam int HOLD_W = FW + 7;
    localparam int CNT_W  = $clog2(HOLD_W + 1);

    logic [HOLD_W-1:0] hold;
    logic [CNT_W-1:0]  cnt;

    assign ready = cnt >= CNT_W'(FW);
    assign field = hold[FW-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold <= '0;
            cnt  <= '0;
        end else if (pop) begin
            hold <= hold >> FW;
            cnt  <= cnt - CNT_W'(FW);
        end else if (push) begin
            hold <= hold | ({{(HOLD_W-8){1'b0}}, din} << cnt);
            cnt  <= cnt + CNT_W'(8);
        end
    end
endmodule

// File: rtl/hdr_acc.sv
module hdr_acc #(
    parameter int FW    = 22,
    parameter int SUM_W = 28
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           add,
    input  logic [FW-1:0]  val,
    output logic [SUM_W:0] sum_nx
);
    logic [SUM_W-1:0] sum;

    assign sum_nx = {1'b0, sum} + (SUM_W+1)'(val);

    always_ff @(posedge clk) begin
        if (rst || clr)                sum <= '0;
        else if (add && !sum_nx[SUM_W]) sum <= sum_nx[SUM_W-1:0];
    end
endmodule

// File: rtl/hdr_size_extract.sv
module hdr_size_extract
    import hdr_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    parameter int IDX_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [7:0]        in_byte,
    input  logic              start,
    output logic              busy,
    output logic              res_valid,
    output logic              res_error,
    output logic [WORD_W-1:0] bs_offset,
    output logic [WORD_W-1:0] data_bytes
);
    localparam int AW    = $clog2(BUF_BYTES);
    localparam int SUM_W = WORD_W - FRAME_LOG2;

    phase_e            phase;
    logic [7:0]        hlen;
    logic [TBL_W-1:0]  ptr;
    logic [2:0]        k;
    logic [7:0]        rec_left;
    logic [7:0]        rec_id;
    logic [23:0]       rec_lo;
    scan_t             sc;
    scan_t             merged;
    logic [7:0]        ncomp_lo;
    logic [15:0]       comp_left;
    logic [WORD_W-1:0] rd_ptr;
    logic              valid_q, err_q;
    logic [WORD_W-1:0] off_q, data_q;

    logic [WORD_W-1:0] raddr_w;
    logic              rd_in;
    logic [7:0]        rdata;
    logic              wr_en;
    logic              unp_ready, unp_push, unp_pop, dp_clr;
    logic [FLD_W-1:0]  fld;
    logic [SUM_W:0]    sum_nx;

    // Byte store
    assign wr_en = in_valid && (phase == PH_IDLE) && (in_index < IDX_W'(BUF_BYTES));

    always_comb begin
        case (phase)
            PH_HLEN:   raddr_w = WORD_W'(HLEN_POS);
            PH_NREC:   raddr_w = WORD_W'(hlen) - WORD_W'(1);
            PH_REC:    raddr_w = WORD_W'(ptr) + WORD_W'(k);
            PH_CNT_LO: raddr_w = WORD_W'(NCOMP_POS);
            PH_CNT_HI: raddr_w = WORD_W'(NCOMP_POS + 1);
            PH_SIZES:  raddr_w = rd_ptr;
            default:   raddr_w = '0;
        endcase
    end

    assign rd_in = raddr_w < WORD_W'(BUF_BYTES);

    hdr_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
        .clk   (clk),
        .wr_en (wr_en),
        .waddr (in_index[AW-1:0]),
        .wdata (in_byte),
        .raddr (raddr_w[AW-1:0]),
        .rdata (rdata)
    );

    // Size-list datapath
    assign dp_clr   = (phase != PH_SIZES);
    assign unp_pop  = (phase == PH_SIZES) && unp_ready;
    assign unp_push = (phase == PH_SIZES) && !unp_ready && rd_in;

    hdr_unpack #(.FW(FLD_W)) u_unp (
        .clk   (clk),
        .rst   (rst),
        .clr   (dp_clr),
        .push  (unp_push),
        .din   (rdata),
        .pop   (unp_pop),
        .ready (unp_ready),
        .field (fld)
    );

    hdr_acc #(.FW(FLD_W), .SUM_W(SUM_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (dp_clr),
        .add    (unp_pop),
        .val    (fld),
        .sum_nx (sum_nx)
    );

    assign merged = merge_rec(sc, rec_id, {rdata, rec_lo});

    // Parse sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            hlen      <= '0;
            ptr       <= '0;
            k         <= '0;
            rec_left  <= '0;
            rec_id    <= '0;
            rec_lo    <= '0;
            sc        <= '0;
            ncomp_lo  <= '0;
            comp_left <= '0;
            rd_ptr    <= '0;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
            off_q     <= '0;
            data_q    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_HLEN;
                        valid_q <= 1'b0;
                        err_q   <= 1'b0;
                        off_q   <= '0;
                        data_q  <= '0;
                        sc      <= '0;
                    end
                end
                PH_HLEN: begin
                    if (rdata == 8'd0 || 32'(rdata) > 32'(BUF_BYTES)) begin
                        phase <= PH_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        hlen  <= rdata;
                        phase <= PH_NREC;
                    end
                end
                PH_NREC: begin
                    if (rdata == 8'd0 || 32'(table_end(hlen, rdata)) > 32'(BUF_BYTES)) begin
                        phase <= PH_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        ptr      <= TBL_W'(hlen);
                        rec_left <= rdata;
                        k        <= '0;
                        phase    <= PH_REC;
                    end
                end
                PH_REC: begin
                    if (k == 3'(REC_LAST)) begin
                        sc <= merged;
                        if (merged.got_stream && merged.got_sizes) begin
                            phase <= PH_CNT_LO;
                        end else if (rec_left == 8'd1) begin
                            phase <= PH_IDLE;
                            err_q <= 1'b1;
                        end else begin
                            rec_left <= rec_left - 8'd1;
                            ptr      <= ptr + TBL_W'(REC_LEN);
                            k        <= '0;
                        end
                    end else begin
                        k <= k + 3'd1;
                        if (k == 3'd0) rec_id <= rdata;
                        else           rec_lo <= {rdata, rec_lo[23:8]};
                    end
                end
                PH_CNT_LO: begin
                    ncomp_lo <= rdata;
                    phase    <= PH_CNT_HI;
                end
                PH_CNT_HI: begin
                    if ({rdata, ncomp_lo} == 16'd0) begin
                        valid_q <= 1'b1;
                        off_q   <= sc.stream_off;
                        phase   <= PH_IDLE;
                    end else begin
                        comp_left <= {rdata, ncomp_lo};
                        rd_ptr    <= sc.sizes_off;
                        phase     <= PH_SIZES;
                    end
                end
                PH_SIZES: begin
                    if (unp_ready) begin
                        if (sum_nx[SUM_W]) begin
                            phase <= PH_IDLE;
                            err_q <= 1'b1;
                        end else if (comp_left == 16'd1) begin
                            valid_q <= 1'b1;
                            off_q   <= sc.stream_off;
                            data_q  <= {sum_nx[SUM_W-1:0], {FRAME_LOG2{1'b0}}};
                            phase   <= PH_IDLE;
                        end else begin
                            comp_left <= comp_left - 16'd1;
                        end
                    end else if (!rd_in) begin
                        phase <= PH_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        rd_ptr <= rd_ptr + WORD_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign res_valid  = valid_q;
    assign res_error  = err_q;
    assign bs_offset  = off_q;
    assign data_bytes = data_q;
endmodule

// File: rtl/hdr_size_extract_chk.sv
module hdr_size_extract_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        res_valid,
    input logic        res_error,
    input logic [31:0] bs_offset,
    input logic [31:0] data_bytes
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_error)); // R10

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_error |-> (bs_offset == 32'd0 && data_bytes == 32'd0)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res_valid) && $stable(res_error)
                               && $stable(bs_offset) && $stable(data_bytes))); // R10

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (data_bytes[3:0] == 4'd0)); // R7

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !res_valid && !res_error)); // R11

    AST_FINISH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (res_valid || res_error)); // R11

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !res_valid && !res_error
                        && bs_offset == 32'd0 && data_bytes == 32'd0)); // R13
endmodule

bind hdr_size_extract hdr_size_extract_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_error  (res_error),
    .bs_offset  (bs_offset),
    .data_bytes (data_bytes)
);

// File: tb/sim_hdr_size_extract.sv
module sim_hdr_size_extract;
    localparam int NB   = 256;
    localparam int HL   = 58;
    localparam int LIST = 104;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_index = '0;
    logic [7:0]  in_byte = '0;
    logic        start = 1'b0;
    logic        busy, res_valid, res_error;
    logic [31:0] bs_offset, data_bytes;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  img [NB];
    logic [21:0] vals [70];

    always #2 clk = ~clk;

    hdr_size_extract u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index),
        .in_byte(in_byte), .start(start), .busy(busy), .res_valid(res_valid),
        .res_error(res_error), .bs_offset(bs_offset), .data_bytes(data_bytes)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic base_img(input int nrec, input int n);
        for (int a = 0; a < NB; a++) img[a] = 8'h00;
        img[24] = 8'(HL);
        img[HL-1] = 8'(nrec);
        img[55] = n[7:0];
        img[56] = n[15:8];
    endtask

    task automatic put_rec(input int r, input logic [7:0] id, input logic [31:0] off);
        int b;
        b = HL + 9 * r;
        img[b] = id;
        for (int q = 0; q < 4; q++) img[b + 1 + q] = off[8*q +: 8];
    endtask

    task automatic put_fld(input int base, input int i, input logic [21:0] v);
        for (int b = 0; b < 22; b++) begin
            int p;
            p = i * 22 + b;
            if (base + p / 8 < NB) img[base + p / 8][p % 8] = v[b];
        end
    endtask

    task automatic wr(input logic [31:0] idx, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_index = idx; in_byte = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load_img();
        @(negedge clk);
        for (int a = 0; a < NB; a++) begin
            in_valid = 1'b1; in_index = 32'(a); in_byte = img[a];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic go(input bit junk, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (cyc < 3000) begin
            if (junk && cyc < 3) begin
                in_valid = 1'b1; in_index = 32'd24; in_byte = 8'h00;
            end else begin
                in_valid = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (res_valid || res_error) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] eoff, input longint edata,
                             input int elat, input bit junk);
        int cyc;
        go(junk, cyc);
        chk(res_valid === 1'b1 && res_error === 1'b0, {tag, " valid"}, res_valid, 1);
        chk(bs_offset === eoff, {tag, " offset"}, bs_offset, eoff);
        chk(longint'(data_bytes) == edata, {tag, " size"}, data_bytes, edata);
        if (elat >= 0) chk(cyc == elat, {tag, " R11 latency"}, cyc, elat);
    endtask

    task automatic expect_err(input string tag);
        int cyc;
        go(1'b0, cyc);
        chk(res_error === 1'b1 && res_valid === 1'b0, {tag, " error"}, res_error, 1);
        chk(bs_offset === 32'd0 && data_bytes === 32'd0, {tag, " R10 zero fields"}, data_bytes, 0);
    endtask

    function automatic int lat(input int j, input int n);
        return 4 + 5 * j + ((n == 0) ? 0 : n + (22 * n + 7) / 8);
    endfunction

    function automatic longint fill_vals(input int n, input int seed);
        longint s;
        s = 0;
        for (int i = 0; i < n; i++) begin
            vals[i] = 22'((i * 32'h2F5A3 + seed * 32'h1B7 + 32'h155) & 32'h3FFFFF);
            if (i == n - 1 && (n % 2) == 1) vals[i] = 22'h3FFFFF;
            s += longint'(vals[i]);
        end
        return s * 16;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        longint ed;
        logic [31:0] off;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        chk(!busy && !res_valid && !res_error && bs_offset == 0 && data_bytes == 0,
            "R13 reset state", {busy, res_valid, res_error}, 0);

        // R1 R2 R3 R6 R7 R11: sweep of counts and record orders
        for (int n = 0; n < 13; n++) begin
            ed  = fill_vals(n, n);
            off = 32'h1000_0000 + 32'(n);
            if (n % 2 == 0) begin
                base_img(2, n);
                put_rec(0, 8'd5, LIST);
                put_rec(1, 8'd8, off);
                for (int i = 0; i < n; i++) put_fld(LIST, i, vals[i]);
                load_img();
                expect_ok($sformatf("R7 sweep n=%0d A", n), off, ed, lat(2, n), 1'b0);
            end else begin
                base_img(5, n);
                put_rec(0, 8'd3, 32'd7);
                put_rec(1, 8'd8, off);
                put_rec(2, 8'hFF, 32'd9);
                put_rec(3, 8'd5, LIST);
                put_rec(4, 8'd8, 32'hDEAD_BEEF); // R4: after both found
                for (int i = 0; i < n; i++) put_fld(LIST, i, vals[i]);
                load_img();
                expect_ok($sformatf("R4 sweep n=%0d B", n), off, ed, lat(4, n), 1'b0);
            end
        end

        // R3: a second payload record before the size record replaces the first
        ed = fill_vals(3, 40);
        base_img(3, 3);
        put_rec(0, 8'd8, 32'h0000_1111);
        put_rec(1, 8'd8, 32'h0000_2222);
        put_rec(2, 8'd5, LIST);
        for (int i = 0; i < 3; i++) put_fld(LIST, i, vals[i]);
        load_img();
        expect_ok("R3 later payload record", 32'h0000_2222, ed, lat(3, 3), 1'b0);

        // R4: walk stops once both found
        base_img(3, 3);
        put_rec(0, 8'd8, 32'h0000_1111);
        put_rec(1, 8'd5, LIST);
        put_rec(2, 8'd8, 32'h0000_2222);
        for (int i = 0; i < 3; i++) put_fld(LIST, i, vals[i]);
        load_img();
        expect_ok("R4 early stop", 32'h0000_1111, ed, lat(2, 3), 1'b0);

        // R5: missing records
        base_img(2, 1);
        put_rec(0, 8'd5, LIST); put_rec(1, 8'd3, 32'd0);
        load_img();
        expect_err("R5 no payload id");
        base_img(2, 1);
        put_rec(0, 8'd8, 32'd5); put_rec(1, 8'd4, LIST);
        load_img();
        expect_err("R5 no size id");
        base_img(0, 1);
        load_img();
        expect_err("R5 zero records");

        // R1: zero header length; R2: table beyond buffer
        base_img(2, 1);
        img[24] = 8'd0;
        load_img();
        expect_err("R1 zero header length");
        base_img(25, 1);
        load_img();
        expect_err("R2 table past buffer");

        // R9: size list runs past the buffer
        base_img(2, 3);
        put_rec(0, 8'd5, 32'd250); put_rec(1, 8'd8, 32'd1);
        load_img();
        expect_err("R9 list past buffer");
        base_img(2, 1);
        put_rec(0, 8'd5, 32'h0001_0000); put_rec(1, 8'd8, 32'd1);
        load_img();
        expect_err("R9 list far outside");

        // R8: boundary and overflow with 65 components from index 76
        base_img(2, 65);
        put_rec(0, 8'd5, 32'd76); put_rec(1, 8'd8, 32'h00AB_CDEF);
        for (int i = 0; i < 64; i++) put_fld(76, i, 22'h3FFFFF);
        put_fld(76, 64, 22'd63);
        load_img();
        expect_ok("R8 largest size", 32'h00AB_CDEF, 64'hFFFF_FFF0, lat(2, 65), 1'b0);
        put_fld(76, 64, 22'd64);
        load_img();
        expect_err("R8 overflow");

        // R12: writes during busy and beyond the buffer are ignored; R10 hold
        ed = fill_vals(5, 77);
        base_img(2, 5);
        put_rec(0, 8'd8, 32'h0BAD_F00D); put_rec(1, 8'd5, LIST);
        for (int i = 0; i < 5; i++) put_fld(LIST, i, vals[i]);
        load_img();
        expect_ok("R12 parse with busy writes", 32'h0BAD_F00D, ed, lat(2, 5), 1'b1);
        expect_ok("R12 rerun after busy writes", 32'h0BAD_F00D, ed, lat(2, 5), 1'b0);
        wr(32'(NB + 24), 8'h00);
        wr(32'h8000_0018, 8'h00);
        repeat (6) @(negedge clk);
        chk(res_valid && bs_offset == 32'h0BAD_F00D && longint'(data_bytes) == ed,
            "R10 result held while idle", data_bytes, ed);
        expect_ok("R12 rerun after far writes", 32'h0BAD_F00D, ed, lat(2, 5), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule